// File: doc/BRIEF.md
# Configurable UART Transmitter

This block is one transmit channel of an asynchronous serial port. A single character buffer takes data written by the host. When the channel is enabled, it passes the buffered character to a shift register. The shift register drives a frame onto the line: a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Between frames the line rests high.

The bit rate comes from a 16x oversampling tick. A reload divider with an 8-bit value `n` produces this tick, so one bit lasts 16·(n+1) periods of the selected source clock. The source clock is one of three things: the system clock, the system clock divided by 8 or 32, or the rising edges of an external clock pin that is synchronised into the clock domain.

The host may write a second character while the first one is still shifting. That character follows with no idle gap between the frames. A single-cycle interrupt pulse marks one of two points, chosen by an input: the hand-off from the buffer to the shift register, or the end of the last stop bit.

Top module: `uart_tx_chan`

## Requirements
- R1: The line `txd_o` is high while idle. A frame starts with one low bit, and the data bits follow least significant bit first.
- R2: `len_sel_i` selects the number of data bits: 0 gives 7, 1 gives 8, and 2 or 3 gives 9. Data bits above the selected length are not sent.
- R3: `par_sel_i` selects the parity bit: 1 gives even, 2 gives odd, and 0 or 3 gives none. With even parity, the data bits and the parity bit together hold an even number of ones. With odd parity they hold an odd number. When enabled, the parity bit comes straight after the last data bit.
- R4: One stop bit is sent when `two_stop_i` is 0 and two when it is 1. Stop bits are high.
- R5: Every bit lasts 16·(n+1) periods of the selected source, where n is `div_n_i`. `clk_src_i` selects the source: 0 is the clock, 1 is the clock divided by 8, 2 is the clock divided by 32, and 3 is the rising edges of `ext_clk_i` after a two-flop synchroniser.
- R6: A frame starts only when `tx_en_i` is 1 and the buffer holds data. A write clears `buf_empty_o`. The hand-off to the shift register sets it again.
- R7: A write to a full buffer replaces the pending character. `buf_empty_o` stays low, and only the last character written is sent.
- R8: If a character is waiting when a frame's last stop bit ends, its start bit follows at once, with no idle time.
- R9: When `irq_sel_i` is 0, `irq_o` pulses for one cycle at each hand-off from the buffer. When it is 1, `irq_o` pulses for one cycle when the last stop bit ends.
- R10: After reset, `txd_o` is 1, `buf_empty_o` is 1, `busy_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External rate clock, asynchronous |
| clk_src_i | input | 2 | Rate source select (0 clk, 1 clk/8, 2 clk/32, 3 external) |
| div_n_i | input | 8 | Reload value n of the rate divider |
| tx_en_i | input | 1 | Transmit enable |
| len_sel_i | input | 2 | Data length select |
| par_sel_i | input | 2 | Parity select |
| two_stop_i | input | 1 | Two stop bits when 1 |
| irq_sel_i | input | 1 | Interrupt point: 0 buffer hand-off, 1 frame end |
| wr_i | input | 1 | Write strobe for the character buffer |
| wr_data_i | input | 9 | Character to write |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Buffer empty flag |
| busy_o | output | 1 | Shift register is sending a frame |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The two counters have different signatures at the port. A phase counter or divider that is off by a count makes bits stretch or shrink. Mid-bit sampling then drifts into the wrong bit within a few bits of the start edge. A bit index or frame-length error shows up as a wrong parity or stop level, or as a missing or extra trailing bit, before the frame would end. A buffer flag that is wrong produces one of three visible faults: a frame that never starts, a frame sent twice, or an idle gap where frames should run back to back. Each of these appears within one frame time.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 13;
  localparam int CNT_W   = 4;

  typedef enum logic [1:0] {SRC_CLK = 2'd0, SRC_DIV8 = 2'd1, SRC_DIV32 = 2'd2, SRC_EXT = 2'd3} src_e;

  function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(7);
      2'd1:    return CNT_W'(8);
      default: return CNT_W'(9);
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] par);
    return (par == 2'd1) || (par == 2'd2);
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic [1:0] sel, input logic [1:0] par,
                                                 input logic two);
    return CNT_W'(1) + data_bits(sel) + CNT_W'(parity_on(par)) + (two ? CNT_W'(2) : CNT_W'(1));
  endfunction

  function automatic logic [FRAME_W-1:0] frame_build(input logic [DATA_W-1:0] d,
                                                     input logic [1:0] sel, input logic [1:0] par);
    logic [FRAME_W-1:0] f;
    logic [CNT_W-1:0]   nd;
    logic               p;
    f  = '1;
    f[0] = 1'b0;
    nd = data_bits(sel);
    p  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nd)) begin
        f[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    if (parity_on(par)) f[CNT_W'(1) + nd] = (par == 2'd2) ? ~p : p;
    return f;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic [1:0]       src_i,
  input  logic [DIV_W-1:0] div_n_i,
  output logic             os_tick_o
);
  import uart_tx_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [2:0]       ext_q;
  logic             ext_rise;
  logic             pre_tick;
  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ext_q   <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      ext_q   <= {ext_q[1:0], ext_clk_i};
    end
  end

  assign ext_rise = ext_q[1] & ~ext_q[2];

  always_comb begin
    case (src_e'(src_i))
      SRC_CLK:   pre_tick = 1'b1;
      SRC_DIV8:  pre_tick = (pre_cnt[2:0] == 3'd7);
      SRC_DIV32: pre_tick = (pre_cnt == {PRE_W{1'b1}});
      default:   pre_tick = ext_rise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        div_cnt <= '0;
    else if (pre_tick && div_cnt == 0) div_cnt <= div_n_i;
    else if (pre_tick)                 div_cnt <= div_cnt - 1'b1;
  end

  assign os_tick_o = pre_tick && (div_cnt == '0);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick_o |=> div_cnt == $past(div_n_i));
  assert_ext_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == 2'd3 && pre_tick) |-> (ext_q[1] && !ext_q[2]));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick_i,
  input  logic              tx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              two_stop_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              busy_o,
  output logic              ev_load_o,
  output logic              ev_done_o
);
  logic [DATA_W-1:0]  buf_q;
  logic               empty_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   phase_q;
  logic [CNT_W-1:0]   idx_q;
  logic [CNT_W-1:0]   nbits_q;
  logic               busy_q;
  logic               bit_end;

  assign bit_end   = busy_q && os_tick_i && (phase_q == {CNT_W{1'b1}});
  assign ev_done_o = bit_end && (idx_q == nbits_q - 1'b1);
  assign ev_load_o = tx_en_i && !empty_q && (!busy_q || ev_done_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      empty_q <= 1'b1;
    end else if (wr_i) begin
      buf_q   <= wr_data_i;
      empty_q <= 1'b0;
    end else if (ev_load_o) begin
      empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      phase_q <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      busy_q  <= 1'b0;
    end else if (ev_load_o) begin
      sh_q    <= frame_build(buf_q, len_sel_i, par_sel_i);
      phase_q <= '0;
      idx_q   <= '0;
      nbits_q <= frame_len(len_sel_i, par_sel_i, two_stop_i);
      busy_q  <= 1'b1;
    end else if (ev_done_o) begin
      busy_q  <= 1'b0;
    end else if (busy_q && os_tick_i) begin
      phase_q <= phase_q + 1'b1;
      if (bit_end) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign txd_o       = busy_q ? sh_q[0] : 1'b1;
  assign buf_empty_o = empty_q;
  assign busy_o      = busy_q;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_o |=> !txd_o);
  assert_load_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_en_i));
  assert_empty_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load_o && !wr_i) |=> empty_q);
  assert_write_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !empty_q);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < nbits_q));
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic [1:0]       clk_src_i,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic             tx_en_i,
  input  logic [1:0]       len_sel_i,
  input  logic [1:0]       par_sel_i,
  input  logic             two_stop_i,
  input  logic             irq_sel_i,
  input  logic             wr_i,
  input  logic [8:0]       wr_data_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             busy_o,
  output logic             irq_o
);
  logic os_tick;
  logic ev_load;
  logic ev_done;
  logic irq_q;

  uart_tx_baud #(.DIV_W(DIV_W), .PRE_W(5)) u_baud (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .src_i(clk_src_i),
    .div_n_i(div_n_i), .os_tick_o(os_tick)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick), .tx_en_i(tx_en_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .len_sel_i(len_sel_i),
    .par_sel_i(par_sel_i), .two_stop_i(two_stop_i), .txd_o(txd_o),
    .buf_empty_o(buf_empty_o), .busy_o(busy_o), .ev_load_o(ev_load),
    .ev_done_o(ev_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_sel_i ? ev_done : ev_load;
  end

  assign irq_o = irq_q;

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && irq_sel_i) |=> irq_o);
endmodule

// File: tb/test_uart_tx_chan.sv
module test_uart_tx_chan;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic [1:0] src = 2'd0, len = 2'd1, par = 2'd0;
  logic [7:0] div_n = 8'd0;
  logic       tx_en = 1'b0, two = 1'b0, irq_sel = 1'b0, wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       txd, buf_empty, busy, irq;

  int cyc = 0, checks = 0, fails = 0, irq_cnt = 0, irq_cyc = 0;

  uart_tx_chan i_uart_tx_chan (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .clk_src_i(src), .div_n_i(div_n),
    .tx_en_i(tx_en), .len_sel_i(len), .par_sel_i(par), .two_stop_i(two),
    .irq_sel_i(irq_sel), .wr_i(wr), .wr_data_i(wdata), .txd_o(txd),
    .buf_empty_o(buf_empty), .busy_o(busy), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  initial begin
    #3;
    forever #(CLK_P*2) ext_clk = ~ext_clk;
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) begin
      irq_cnt <= irq_cnt + 1;
      irq_cyc <= cyc;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_data(input logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd1) ? 8 : 9;
  endfunction

  function automatic int bit_period(input logic [1:0] s, input int n);
    int pre;
    pre = (s == 2'd0) ? 1 : (s == 2'd1) ? 8 : (s == 2'd2) ? 32 : 4;
    return 16 * (n + 1) * pre;
  endfunction

  // Expected line value for position k of the frame.
  function automatic int exp_bit(input logic [8:0] d, input int k);
    int nd, ones;
    bit has_p;
    nd = n_data(len);
    has_p = (par == 2'd1) || (par == 2'd2);
    if (k == 0) return 0;
    if (k <= nd) return int'(d[k-1]);
    if (has_p && k == nd + 1) begin
      ones = 0;
      for (int i = 0; i < nd; i++) ones += int'(d[i]);
      return (par == 2'd1) ? (ones % 2) : 1 - (ones % 2);
    end
    return 1;
  endfunction

  function automatic int frame_bits();
    return 1 + n_data(len) + (((par == 2'd1) || (par == 2'd2)) ? 1 : 0) + (two ? 2 : 1);
  endfunction

  task automatic write_char(input logic [8:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // Waits for a start edge, samples each bit at its centre.
  task automatic recv(input logic [8:0] d, input string req, output int t0, output int last);
    int b, guard, nb;
    b = bit_period(src, int'(div_n));
    guard = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    t0 = cyc;
    chk(guard < 20000, {req, " start"}, guard, 0);
    nb = frame_bits();
    last = t0;
    for (int k = 0; k < nb; k++) begin
      while (cyc < t0 + k * b + b / 2) @(negedge clk);
      last = cyc;
      chk(int'(txd) == exp_bit(d, k), $sformatf("%s bit%0d", req, k), int'(txd), exp_bit(d, k));
    end
  endtask

  task automatic frame_test(input logic [8:0] d, input string req);
    int t0, last, c0, b;
    b = bit_period(src, int'(div_n));
    c0 = irq_cnt;
    write_char(d);
    recv(d, req, t0, last);
    if (!irq_sel)
      chk(irq_cnt == c0 + 1 && irq_cyc - t0 >= -1 && irq_cyc - t0 <= 2, "R9 load irq",
          irq_cyc - t0, 1);
    else begin
      while (cyc < last + b / 2 + 8) @(negedge clk);
      chk(irq_cnt == c0 + 1 && irq_cyc > last && irq_cyc <= last + b / 2 + 8, "R9 end irq",
          irq_cyc - last, b / 2);
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    int t0, last, t1, last1, lows, b;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(txd === 1'b1, "R10 txd", int'(txd), 1);
    chk(buf_empty === 1'b1, "R10 empty", int'(buf_empty), 1);
    chk(busy === 1'b0 && irq === 1'b0, "R10 busy/irq", int'(busy) + int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: disabled channel holds the character
    write_char(9'h055);
    chk(buf_empty === 1'b0, "R6 empty after write", int'(buf_empty), 0);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!txd || busy) lows++; end
    chk(lows == 0, "R6 no start while disabled", lows, 0);

    // R7: overwrite while full
    write_char(9'h0A3);
    chk(buf_empty === 1'b0, "R7 still full", int'(buf_empty), 0);
    @(negedge clk); tx_en = 1'b1;
    recv(9'h0A3, "R7 last write sent", t0, last);
    chk(buf_empty === 1'b1, "R6 empty after load", int'(buf_empty), 1);
    while (busy) @(negedge clk);
    lows = 0;
    repeat (200) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R7 single frame", lows, 0);

    // Directed corners: 9 bits odd two stops, 7 bits even with high bits masked
    len = 2'd2; par = 2'd2; two = 1'b1; div_n = 8'd2;
    frame_test(9'h1FF, "R2 R3 R4 nine odd");
    len = 2'd0; par = 2'd1; two = 1'b0; irq_sel = 1'b1;
    frame_test(9'h1FF, "R2 R3 seven even");
    len = 2'd3; par = 2'd3; two = 1'b0; irq_sel = 1'b0;
    frame_test(9'h100, "R2 R3 code3");

    // R5 rate sources
    len = 2'd1; par = 2'd0; div_n = 8'd1; src = 2'd1;
    frame_test(9'h0C5, "R5 div8");
    div_n = 8'd0; src = 2'd2;
    frame_test(9'h03A, "R5 div32");
    div_n = 8'd1; src = 2'd3;
    frame_test(9'h096, "R5 ext");
    src = 2'd0;

    // R1..R5 random frames
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      len = 2'($urandom_range(0, 3)); par = 2'($urandom_range(0, 3));
      two = 1'($urandom_range(0, 1)); irq_sel = 1'($urandom_range(0, 1));
      div_n = 8'($urandom_range(0, 3));
      frame_test(9'($urandom), "R1 R5 random");
    end

    // R8 back to back
    irq_sel = 1'b0; len = 2'd1; par = 2'd1; two = 1'b1; div_n = 8'd1;
    b = bit_period(src, 1);
    write_char(9'h05A);
    while (buf_empty !== 1'b1) @(negedge clk);
    write_char(9'h0E1);
    recv(9'h05A, "R8 first", t0, last);
    recv(9'h0E1, "R8 second", t1, last1);
    chk(t1 - last >= b / 2 - 4 && t1 - last <= b / 2 + 4, "R8 no gap", t1 - last, b / 2);
    while (busy) @(negedge clk);
    summary();
  end
endmodule